// File: doc/BRIEF.md
# Host Service Latency Watchdog

This block guards the data-transfer phase of a disk controller against a host that is too slow. Whenever a service request to the host goes high (the DMA request line or the interrupt line), a cycle timer starts. The timer stops when the host's response strobe (DMA acknowledge, read strobe or write strobe) returns low. If the allowed number of cycles for the selected data rate runs out first, the block sets a sticky overrun flag for the transfer status byte. In the same cycle it raises a one-cycle abort request so that the command sequencer can stop the transfer.

The allowed service time depends on the data rate. It is 6 µs at 1 Mb/s, 14 µs at 500 kb/s, 30 µs at 250 kb/s and 62 µs at 125 kb/s. Each time is turned into a cycle count from the `CLK_HZ` parameter, rounding down. Watching takes place only while the execution-phase enable is high. A new command start clears the flag and re-arms the block.

The controller has three states. IDLE waits for a request edge. TIMING counts service cycles. TRIPPED holds the overrun. The transitions are:
- IDLE→TIMING on a request rising edge while enabled.
- TIMING→IDLE on an acknowledge falling edge, on loss of the enable, or on a command start.
- TIMING→TRIPPED when the limit is reached.
- TRIPPED→IDLE on a command start.
- IDLE→IDLE and TRIPPED→TRIPPED in every other case.

Top module: `svc_latency_guard`

## Requirements
- R1: After reset `overrun_flag` and `abort_pulse` are 0 and the block is idle.
- R2: Timing starts only on a clock edge where the OR of `req_dma` and `req_irq` is seen rising while `exec_en` is 1. A request that rose while `exec_en` was 0 and is still high when `exec_en` returns does not start timing.
- R3: A falling edge of the OR of `ack_dack`, `ack_rd` and `ack_wr` stops the timer with no overrun, provided it is seen at most LIMIT clock edges after the edge that saw the request rise.
- R4: LIMIT = floor(CLK_HZ × T / 1 000 000) cycles, where T in µs is chosen by `rate_sel`: 0 = 125 kb/s, T = 62; 1 = 250 kb/s, T = 30; 2 = 500 kb/s, T = 14; 3 = 1 Mb/s, T = 6.
- R5: With no acknowledge fall, `overrun_flag` becomes 1 right after the LIMIT-th clock edge that follows the edge that saw the request rise, and not earlier.
- R6: `abort_pulse` is 1 for exactly one cycle, the first cycle in which `overrun_flag` is 1.
- R7: Once set, `overrun_flag` stays 1 until `cmd_start`. While it is set, new requests raise no further abort.
- R8: `cmd_start` has priority over every other input. It clears `overrun_flag` on the next edge and abandons any running timer.
- R9: A new request rising edge while the timer is running does not restart it.
- R10: Deasserting `exec_en` while the timer runs abandons it, and no overrun follows.
- R11: `rate_sel` is captured at the request edge. Changing it during a running window does not change that window's limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | High during the execution phase of a command |
| cmd_start | input | 1 | One-cycle pulse at the start of each new command |
| rate_sel | input | 2 | Data rate select (encoding in R4) |
| req_dma | input | 1 | DMA service request to the host |
| req_irq | input | 1 | Interrupt service request to the host |
| ack_dack | input | 1 | DMA acknowledge from the host |
| ack_rd | input | 1 | Host read strobe |
| ack_wr | input | 1 | Host write strobe |
| overrun_flag | output | 1 | Sticky overrun status bit |
| abort_pulse | output | 1 | One-cycle request to abort the transfer |

## Verification
The assertions take for granted that all strobes are already synchronous to `clk`, that `rate_sel` only holds defined codes, and that `cmd_start` is a single-cycle pulse. The stimulus meets these assumptions by driving every input on the falling clock edge and raising `cmd_start` for exactly one cycle. Acknowledge strobes are raised together with the request and dropped at a chosen cycle, so each window ends on a falling edge at a known count. Request lines are lowered for at least one cycle before a new rising edge is wanted.

// File: rtl/svc_guard_pkg.sv
package svc_guard_pkg;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_TIMING  = 2'd1,
        GS_TRIPPED = 2'd2
    } guard_state_t;

    // Allowed host service time in microseconds per rate code.
    function automatic int unsigned budget_us(input logic [1:0] rate);
        int unsigned us;
        case (rate)
            2'd0:    us = 62;
            2'd1:    us = 30;
            2'd2:    us = 14;
            default: us = 6;
        endcase
        return us;
    endfunction

    // Allowed service time in clock cycles, rounded down.
    function automatic int unsigned budget_cycles(input longint unsigned clk_hz,
                                                  input logic [1:0] rate);
        longint unsigned prod;
        prod = clk_hz * 64'(budget_us(rate));
        return 32'(prod / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/sig_edge.sv
module sig_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= d;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = d & ~prev_q;
        end else begin : g_fall
            assign pulse = ~d & prev_q;
        end
    endgenerate
endmodule

// File: rtl/rate_limit_lut.sv
module rate_limit_lut
    import svc_guard_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd8_000_000,
    parameter int unsigned     CW     = 9
) (
    input  logic [1:0]    rate_sel,
    output logic [CW-1:0] limit
);
    localparam int unsigned NRATES = 4;

    logic [CW-1:0] table_w [NRATES];

    generate
        for (genvar g = 0; g < NRATES; g++) begin : g_rate
            localparam int unsigned LIM = budget_cycles(CLK_HZ, 2'(g));
            assign table_w[g] = CW'(LIM);
        end
    endgenerate

    assign limit = table_w[rate_sel];
endmodule

// File: rtl/run_timer.sv
module run_timer #(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [CW-1:0] limit_in,
    output logic          expired
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    // The load edge counts as elapsed cycle 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(1);
            lim_q <= limit_in;
        end else if (advance && (cnt_q != '1)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q >= lim_q);
endmodule

// File: rtl/svc_latency_guard.sv
module svc_latency_guard
    import svc_guard_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd8_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exec_en,
    input  logic       cmd_start,
    input  logic [1:0] rate_sel,
    input  logic       req_dma,
    input  logic       req_irq,
    input  logic       ack_dack,
    input  logic       ack_rd,
    input  logic       ack_wr,
    output logic       overrun_flag,
    output logic       abort_pulse
);
    localparam int unsigned MAX_LIMIT = budget_cycles(CLK_HZ, 2'd0);
    localparam int unsigned CW        = $clog2(MAX_LIMIT + 1) + 1;

    logic          req_any, ack_any;
    logic          req_rise, ack_fall;
    logic [CW-1:0] limit_sel;
    logic          expired;
    logic          start_timer;
    guard_state_t  state_q, state_d;

    assign req_any = req_dma | req_irq;
    assign ack_any = ack_dack | ack_rd | ack_wr;

    sig_edge #(.RISING(1'b1)) u_req_edge (
        .clk(clk), .rst_n(rst_n), .d(req_any), .pulse(req_rise)
    );

    sig_edge #(.RISING(1'b0)) u_ack_edge (
        .clk(clk), .rst_n(rst_n), .d(ack_any), .pulse(ack_fall)
    );

    rate_limit_lut #(.CLK_HZ(CLK_HZ), .CW(CW)) u_lut (
        .rate_sel(rate_sel), .limit(limit_sel)
    );

    run_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_timer),
        .advance  (state_q == GS_TIMING),
        .limit_in (limit_sel),
        .expired  (expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_start) begin
            state_d = GS_IDLE;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (exec_en && req_rise) state_d = GS_TIMING;
                end
                GS_TIMING: begin
                    if (!exec_en)      state_d = GS_IDLE;
                    else if (ack_fall) state_d = GS_IDLE;
                    else if (expired)  state_d = GS_TRIPPED;
                end
                GS_TRIPPED: state_d = GS_TRIPPED;
                default:    state_d = GS_IDLE;
            endcase
        end
    end

    assign start_timer = (state_q == GS_IDLE) && (state_d == GS_TIMING);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun_flag <= 1'b0;
            abort_pulse  <= 1'b0;
        end else begin
            overrun_flag <= (state_d == GS_TRIPPED);
            abort_pulse  <= (state_q == GS_TIMING) && (state_d == GS_TRIPPED);
        end
    end
endmodule

// File: rtl/svc_latency_guard_chk.sv
module svc_latency_guard_chk
    import svc_guard_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         exec_en,
    input logic         cmd_start,
    input logic         overrun_flag,
    input logic         abort_pulse,
    input guard_state_t state
);
    assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    assert_abort_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_flag) |-> abort_pulse);

    assert_abort_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> overrun_flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && !cmd_start) |=> overrun_flag);

    assert_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!overrun_flag && !abort_pulse));

    assert_idle_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en && state != GS_TIMING) |=> state != GS_TIMING);

    assert_exec_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_TIMING && !exec_en) |=> (!overrun_flag && state == GS_IDLE));

    assert_trip_from_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(state) == GS_TIMING);
endmodule

bind svc_latency_guard svc_latency_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_en      (exec_en),
    .cmd_start    (cmd_start),
    .overrun_flag (overrun_flag),
    .abort_pulse  (abort_pulse),
    .state        (state_q)
);

// File: tb/svc_latency_guard_tb.sv
module svc_latency_guard_tb;
    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned HZ         = 64'd8_000_000;
    localparam int              WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b1;
    logic       cmd_start = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       req_dma = 1'b0, req_irq = 1'b0;
    logic       ack_dack = 1'b0, ack_rd = 1'b0, ack_wr = 1'b0;
    logic       overrun_flag, abort_pulse;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    svc_latency_guard #(.CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .cmd_start(cmd_start),
        .rate_sel(rate_sel), .req_dma(req_dma), .req_irq(req_irq),
        .ack_dack(ack_dack), .ack_rd(ack_rd), .ack_wr(ack_wr),
        .overrun_flag(overrun_flag), .abort_pulse(abort_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int lim_of(input int r);
        longint unsigned us;
        case (r)
            0:       us = 62;
            1:       us = 30;
            2:       us = 14;
            default: us = 6;
        endcase
        return int'((HZ * us) / 64'd1_000_000);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ack(input int line, input logic v);
        case (line)
            0:       ack_dack = v;
            1:       ack_rd   = v;
            default: ack_wr   = v;
        endcase
    endtask

    task automatic clear_all();
        req_dma = 0; req_irq = 0; ack_dack = 0; ack_rd = 0; ack_wr = 0;
        exec_en = 1;
        cmd_start = 1;
        step(1);
        cmd_start = 0;
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        check("R1 flag in reset", overrun_flag, 1'b0);
        check("R1 abort in reset", abort_pulse, 1'b0);
        rst_n = 1'b1;
        step(3);
        check("R1 flag after reset", overrun_flag, 1'b0);
        check("R1 abort after reset", abort_pulse, 1'b0);
    endtask

    // Acknowledge falls exactly at the limit: no overrun (R3, R4).
    task automatic t_pass(input int rate, input int line);
        int lim = lim_of(rate);
        clear_all();
        rate_sel = 2'(rate);
        req_dma = 1; set_ack(line, 1'b1);
        step(lim);
        set_ack(line, 1'b0);
        step(1);
        check($sformatf("R3 R4 rate%0d line%0d in-time flag", rate, line), overrun_flag, 1'b0);
        check($sformatf("R3 rate%0d line%0d in-time abort", rate, line), abort_pulse, 1'b0);
        step(lim + 5);
        check($sformatf("R3 rate%0d timer stopped", rate), overrun_flag, 1'b0);
        req_dma = 0;
    endtask

    // No acknowledge: flag rises right after the limit edge (R4, R5, R6).
    task automatic t_trip(input int rate);
        int lim = lim_of(rate);
        clear_all();
        rate_sel = 2'(rate);
        req_irq = 1; ack_rd = 1;
        step(lim);
        check($sformatf("R5 rate%0d no flag before limit", rate), overrun_flag, 1'b0);
        step(1);
        check($sformatf("R4 R5 rate%0d flag at limit", rate), overrun_flag, 1'b1);
        check($sformatf("R6 rate%0d abort at limit", rate), abort_pulse, 1'b1);
        step(1);
        check($sformatf("R6 rate%0d abort one cycle", rate), abort_pulse, 1'b0);
        check($sformatf("R7 rate%0d flag held", rate), overrun_flag, 1'b1);
    endtask

    task automatic t_sticky_and_clear();
        int seen_abort = 0;
        t_trip(3);
        req_irq = 0; ack_rd = 0;
        step(2);
        req_dma = 1; ack_dack = 1;
        for (int i = 0; i < lim_of(3) + 5; i++) begin
            step(1);
            if (abort_pulse) seen_abort++;
        end
        check("R7 no abort while tripped", seen_abort != 0, 1'b0);
        check("R7 flag still set", overrun_flag, 1'b1);
        cmd_start = 1;
        step(1);
        cmd_start = 0;
        check("R8 cmd_start clears flag", overrun_flag, 1'b0);
        req_dma = 0; ack_dack = 0;
        // cmd_start during a running window abandons it
        step(2);
        rate_sel = 2'd3;
        req_dma = 1;
        step(5);
        cmd_start = 1;
        step(1);
        cmd_start = 0;
        step(lim_of(3) + 5);
        check("R8 cmd_start abandons timer", overrun_flag, 1'b0);
        req_dma = 0;
    endtask

    task automatic t_no_restart();
        int lim = lim_of(2);
        clear_all();
        rate_sel = 2'd2;
        req_dma = 1; ack_dack = 1;
        step(50);
        req_dma = 0;
        step(1);
        req_irq = 1;
        step(lim - 51);
        check("R9 no flag before original limit", overrun_flag, 1'b0);
        step(1);
        check("R9 flag at original limit", overrun_flag, 1'b1);
    endtask

    task automatic t_exec_drop();
        int lim = lim_of(3);
        clear_all();
        rate_sel = 2'd3;
        req_dma = 1; ack_wr = 1;
        step(10);
        exec_en = 0;
        step(lim + 5);
        check("R10 no overrun after exec drop", overrun_flag, 1'b0);
        exec_en = 1;
        step(lim + 5);
        check("R10 R2 held request not restarted", overrun_flag, 1'b0);
    endtask

    task automatic t_gate();
        int lim = lim_of(3);
        clear_all();
        rate_sel = 2'd3;
        exec_en = 0;
        req_dma = 1;
        step(2);
        exec_en = 1;
        step(lim + 5);
        check("R2 request before enable ignored", overrun_flag, 1'b0);
        req_dma = 0;
        step(1);
        req_dma = 1;
        step(lim);
        check("R2 enabled request before limit", overrun_flag, 1'b0);
        step(1);
        check("R2 enabled request trips", overrun_flag, 1'b1);
    endtask

    task automatic t_rate_latch();
        int lim = lim_of(3);
        clear_all();
        rate_sel = 2'd3;
        req_irq = 1;
        step(2);
        rate_sel = 2'd0;
        step(lim - 2);
        check("R11 no flag before captured limit", overrun_flag, 1'b0);
        step(1);
        check("R11 captured rate limit used", overrun_flag, 1'b1);
    endtask

    initial begin
        t_reset();
        for (int r = 0; r < 4; r++) t_pass(r, r % 3);
        for (int r = 0; r < 4; r++) t_trip(r);
        t_sticky_and_clear();
        t_no_restart();
        t_exec_drop();
        t_gate();
        t_rate_latch();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule